// File: doc/BRIEF.md
# Banked Stack Pointer Control Unit

This unit holds the two-bit processor control word that sets the privilege of thread-mode code and chooses which of two banked stack pointers serves the generic stack pointer. One bank is the main stack and the other is the process stack. A privileged register port reads and writes the control word. A mode input says whether the core runs in handler or thread mode. Exception entry and exception return strobes let the unit generate and consume return codes.

The unit drives the effective stack select and an effective privileged flag. It steers generic stack pointer reads and writes onto the selected bank, and it keeps every written stack pointer word-aligned.

In handler mode the main stack is always active. The stack-select bit reads as zero there and ignores software writes. Exception return is the only path that rewrites the stored thread-mode stack choice.

Top module: `stack_sel_ctrl`

## Requirements
- R1: After reset the control word is 0, `sp_sel_o` is 0 (main), `priv_o` is 1, `ret_err_o` is 0, both banked stack pointers are 0 and `exc_code_o` is 0xFFFFFFF9.
- R2: A privileged read returns bit 0 as the thread-unprivileged flag (1 = unprivileged), bit 1 as the visible stack select (0 = main, 1 = process) and zeros in bits 31:2.
- R3: A privileged write in thread mode loads both bits from `csr_wdata_i[1:0]` at the next clock edge, and `sp_sel_o` follows bit 1.
- R4: While `handler_i` is 1, `sp_sel_o` is 0 and read bit 1 is 0. A write in handler mode loads bit 0 only and leaves the stored stack select unchanged.
- R5: `priv_o` is 1 whenever `handler_i` is 1. In thread mode it is the inverse of bit 0.
- R6: Unprivileged reads return 0, and unprivileged writes leave the control word unchanged. Privilege comes back only through a write made in handler mode.
- R7: A return strobe with code 0xFFFFFFF9 clears the stored stack select, and 0xFFFFFFFD sets it. 0xFFFFFFF1 leaves it unchanged. The new value is visible after the next clock edge.
- R8: Any other return code sets `ret_err_o` for exactly the cycle after the strobe and changes no state.
- R9: During an entry strobe `sp_sel_o` is 0. After the edge, `exc_code_o` holds 0xFFFFFFF1 if entry came from handler mode. From thread mode it holds 0xFFFFFFF9 if the stored stack select was main and 0xFFFFFFFD if it was process.
- R10: `sp_rdata_o` shows the bank chosen by `sp_sel_o`. A stack pointer write stores `sp_wdata_i` with bits 1:0 cleared into that bank only.
- R11: When a return strobe and a privileged control write arrive in the same cycle, the return code decides the stored stack select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| handler_i | input | 1 | 1 = handler mode, 0 = thread mode |
| csr_we_i | input | 1 | Control word write strobe |
| csr_wdata_i | input | 2 | Write data for the control bits |
| csr_rdata_o | output | 32 | Control word read data |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_code_o | output | 32 | Return code captured at the last entry |
| ret_valid_i | input | 1 | Exception return strobe |
| ret_code_i | input | 32 | Return code presented with the strobe |
| ret_err_o | output | 1 | Invalid return code flag, one cycle |
| sp_we_i | input | 1 | Generic stack pointer write strobe |
| sp_wdata_i | input | 32 | Generic stack pointer write data |
| sp_rdata_o | output | 32 | Generic stack pointer read data |
| sp_sel_o | output | 1 | Effective stack select, 1 = process |
| priv_o | output | 1 | Effective privileged flag |

## Verification
A corrupted stored stack select shows on the next generic stack pointer read in thread mode, because the wrong bank's value appears. It shows in the same cycle on `sp_sel_o` and in the return code of the next entry. A corrupted privilege bit shows at once on `priv_o`, and again on the next read, which returns zero instead of the word. The sequence passes through handler mode and then returns to thread mode, so a wrongly accepted handler-mode write to the stack select becomes visible right after the return.

// File: rtl/stkctl_pkg.sv
`timescale 1ns/1ps
package stkctl_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CTRL_W = 2;
  localparam int unsigned NBANK  = 2;
  typedef logic [XLEN-1:0] word_t;

  localparam word_t RET_HND      = 32'hFFFF_FFF1;
  localparam word_t RET_THR_MAIN = 32'hFFFF_FFF9;
  localparam word_t RET_THR_PROC = 32'hFFFF_FFFD;

  function automatic word_t word_align(word_t w);
    return w & ~word_t'(3);
  endfunction
endpackage

// File: rtl/stkctl_ctrl_reg.sv
`timescale 1ns/1ps
module stkctl_ctrl_reg
  import stkctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              handler_i,
  input  logic              csr_we_i,
  input  logic [CTRL_W-1:0] csr_wdata_i,
  input  logic              ret_valid_i,
  input  word_t             ret_code_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ret_err_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              err_q, err_d;
  logic              priv;

  assign priv = handler_i | ~ctrl_q[0];

  always_comb begin
    ctrl_d = ctrl_q;
    err_d  = 1'b0;
    if (csr_we_i && priv) begin
      ctrl_d[0] = csr_wdata_i[0];
      if (!handler_i) ctrl_d[1] = csr_wdata_i[1];
    end
    // return code owns the stack select; bad code cancels everything
    if (ret_valid_i) begin
      case (ret_code_i)
        RET_THR_MAIN: ctrl_d[1] = 1'b0;
        RET_THR_PROC: ctrl_d[1] = 1'b1;
        RET_HND:      ctrl_d[1] = ctrl_q[1];
        default: begin
          ctrl_d = ctrl_q;
          err_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign ret_err_o = err_q;
endmodule

// File: rtl/stkctl_exc_code.sv
`timescale 1ns/1ps
module stkctl_exc_code
  import stkctl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  entry_i,
  input  logic  handler_i,
  input  logic  thr_proc_i,
  output word_t code_o
);
  word_t code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= RET_THR_MAIN;
    else if (entry_i) code_q <= handler_i  ? RET_HND :
                                thr_proc_i ? RET_THR_PROC : RET_THR_MAIN;
  end

  assign code_o = code_q;
endmodule

// File: rtl/stkctl_sp_bank.sv
`timescale 1ns/1ps
module stkctl_sp_bank
  import stkctl_pkg::*;
#(
  parameter word_t MSP_INIT = '0,
  parameter word_t PSP_INIT = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_i,
  input  logic  we_i,
  input  word_t wdata_i,
  output word_t rdata_o,
  output word_t msp_o,
  output word_t psp_o
);
  word_t bank_q [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam word_t INIT = (g == 0) ? MSP_INIT : PSP_INIT;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         bank_q[g] <= word_align(INIT);
      else if (we_i && (int'(sel_i) == g)) bank_q[g] <= word_align(wdata_i);
    end
  end

  assign rdata_o = bank_q[sel_i];
  assign msp_o   = bank_q[0];
  assign psp_o   = bank_q[1];
endmodule

// File: rtl/stack_sel_ctrl.sv
`timescale 1ns/1ps
module stack_sel_ctrl
  import stkctl_pkg::*;
#(
  parameter word_t MSP_INIT = '0,
  parameter word_t PSP_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              handler_i,
  input  logic              csr_we_i,
  input  logic [CTRL_W-1:0] csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  input  logic              exc_entry_i,
  output logic [XLEN-1:0]   exc_code_o,
  input  logic              ret_valid_i,
  input  logic [XLEN-1:0]   ret_code_i,
  output logic              ret_err_o,
  input  logic              sp_we_i,
  input  logic [XLEN-1:0]   sp_wdata_i,
  output logic [XLEN-1:0]   sp_rdata_o,
  output logic              sp_sel_o,
  output logic              priv_o
);
  logic [CTRL_W-1:0] ctrl_q;
  word_t             msp_q, psp_q;
  logic              sel_vis;

  stkctl_ctrl_reg i_ctrl (
    .clk_i, .rst_ni, .handler_i, .csr_we_i, .csr_wdata_i,
    .ret_valid_i, .ret_code_i,
    .ctrl_o    (ctrl_q),
    .ret_err_o (ret_err_o)
  );

  stkctl_exc_code i_code (
    .clk_i, .rst_ni,
    .entry_i    (exc_entry_i),
    .handler_i  (handler_i),
    .thr_proc_i (ctrl_q[1]),
    .code_o     (exc_code_o)
  );

  stkctl_sp_bank #(.MSP_INIT(MSP_INIT), .PSP_INIT(PSP_INIT)) i_bank (
    .clk_i, .rst_ni,
    .sel_i   (sp_sel_o),
    .we_i    (sp_we_i),
    .wdata_i (sp_wdata_i),
    .rdata_o (sp_rdata_o),
    .msp_o   (msp_q),
    .psp_o   (psp_q)
  );

  assign sel_vis     = ~handler_i & ctrl_q[1];
  assign sp_sel_o    = sel_vis & ~exc_entry_i;
  assign priv_o      = handler_i | ~ctrl_q[0];
  assign csr_rdata_o = priv_o ? {{(XLEN-CTRL_W){1'b0}}, sel_vis, ctrl_q[0]} : '0;
endmodule

// File: rtl/stkctl_chk.sv
`timescale 1ns/1ps
module stkctl_chk
  import stkctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              handler_i,
  input logic              exc_entry_i,
  input logic              ret_valid_i,
  input logic [XLEN-1:0]   ret_code_i,
  input logic              sp_we_i,
  input logic [XLEN-1:0]   sp_wdata_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic [XLEN-1:0]   exc_code_o,
  input logic              ret_err_o,
  input logic              sp_sel_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input word_t             msp_q,
  input word_t             psp_q
);
  logic bad_code;
  assign bad_code = ret_code_i != RET_HND && ret_code_i != RET_THR_MAIN &&
                    ret_code_i != RET_THR_PROC;

  assert_hnd_main_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_i |-> !sp_sel_o && !csr_rdata_o[1]);

  assert_no_regain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[0] && !handler_i |=> ctrl_q[0]);

  assert_ret_proc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_code_i == RET_THR_PROC |=> ctrl_q[1]);

  assert_bad_ret_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && bad_code |=> ret_err_o && ctrl_q == $past(ctrl_q));

  assert_entry_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i && !handler_i && ctrl_q[1] |=> exc_code_o == RET_THR_PROC);

  assert_sp_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_i && !sp_sel_o |=> msp_q == word_align($past(sp_wdata_i)) && $stable(psp_q));
endmodule

bind stack_sel_ctrl stkctl_chk i_chk (.*);

// File: tb/test_stack_sel_ctrl.sv
`timescale 1ns/1ps
module test_stack_sel_ctrl;
  localparam int O_RD = 0, O_SEL = 1, O_PRIV = 2, O_SPR = 3, O_CODE = 4, O_ERR = 5;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        handler_i = 1'b0, csr_we_i = 1'b0, exc_entry_i = 1'b0;
  logic        ret_valid_i = 1'b0, sp_we_i = 1'b0;
  logic [1:0]  csr_wdata_i = '0;
  logic [31:0] ret_code_i = '0, sp_wdata_i = '0;
  logic [31:0] csr_rdata_o, exc_code_o, sp_rdata_o;
  logic        ret_err_o, sp_sel_o, priv_o;

  typedef struct { int obs; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event  sample_ev;
  int    checks = 0, errors = 0;
  bit    done = 0;

  always #2 clk_i = ~clk_i;

  stack_sel_ctrl i_stack_sel_ctrl (.*);

  // monitor: pops expected items and compares with the ports
  initial forever begin
    @(sample_ev);
    #0.2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.obs)
        O_RD:    act = csr_rdata_o;
        O_SEL:   act = 32'(sp_sel_o);
        O_PRIV:  act = 32'(priv_o);
        O_SPR:   act = sp_rdata_o;
        O_CODE:  act = exc_code_o;
        default: act = 32'(ret_err_o);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: obs %0d actual %h expected %h", it.tag, it.obs, act, it.exp);
      end
    end
  end

  task automatic expect_val(int obs, logic [31:0] exp, string tag);
    q.push_back('{obs, exp, tag});
  endtask

  task automatic flush();
    -> sample_ev;
    #0.4;
  endtask

  // one cycle of stimulus, cleared at the following negedge
  task automatic drive(bit we, logic [1:0] wd, bit rv, logic [31:0] code,
                       bit ent, bit spw, logic [31:0] spd);
    @(negedge clk_i);
    csr_we_i = we; csr_wdata_i = wd; ret_valid_i = rv; ret_code_i = code;
    exc_entry_i = ent; sp_we_i = spw; sp_wdata_i = spd;
    @(negedge clk_i);
    csr_we_i = 0; ret_valid_i = 0; exc_entry_i = 0; sp_we_i = 0;
  endtask

  task automatic csr_wr(logic [1:0] d);  drive(1, d, 0, 0, 0, 0, 0); endtask
  task automatic ret(logic [31:0] c);    drive(0, 0, 1, c, 0, 0, 0); endtask
  task automatic sp_wr(logic [31:0] d);  drive(0, 0, 0, 0, 0, 1, d); endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_val(O_RD, 0, "R1"); expect_val(O_SEL, 0, "R1");
    expect_val(O_PRIV, 1, "R1"); expect_val(O_ERR, 0, "R1");
    expect_val(O_SPR, 0, "R1"); expect_val(O_CODE, 32'hFFFF_FFF9, "R1");
    flush();

    sp_wr(32'h2000_1003);
    expect_val(O_SPR, 32'h2000_1000, "R10 main aligned"); flush();

    csr_wr(2'b10);
    expect_val(O_RD, 2, "R2 R3"); expect_val(O_SEL, 1, "R3");
    expect_val(O_PRIV, 1, "R5"); expect_val(O_SPR, 0, "R10 process bank");
    flush();
    sp_wr(32'h3000_0007);
    expect_val(O_SPR, 32'h3000_0004, "R10 process aligned"); flush();
    csr_wr(2'b00);
    expect_val(O_RD, 0, "R3 clear"); expect_val(O_SPR, 32'h2000_1000, "R10 main untouched");
    flush();
    csr_wr(2'b10);
    expect_val(O_SPR, 32'h3000_0004, "R10 process kept"); flush();

    // entry from thread on process stack
    @(negedge clk_i);
    exc_entry_i = 1;
    #0.4;
    expect_val(O_SEL, 0, "R9 entry forces main"); flush();
    @(negedge clk_i);
    exc_entry_i = 0;
    handler_i = 1;
    #0.4;
    expect_val(O_CODE, 32'hFFFF_FFFD, "R9 thread process");
    expect_val(O_SEL, 0, "R4"); expect_val(O_RD, 0, "R4 reads zero");
    expect_val(O_PRIV, 1, "R5 handler"); expect_val(O_SPR, 32'h2000_1000, "R10 handler main");
    flush();

    csr_wr(2'b01);
    expect_val(O_RD, 1, "R4 bit0 written"); expect_val(O_PRIV, 1, "R5 handler"); flush();
    csr_wr(2'b00);
    expect_val(O_RD, 0, "R4"); flush();
    drive(0, 0, 0, 0, 1, 0, 0);
    expect_val(O_CODE, 32'hFFFF_FFF1, "R9 handler entry"); flush();

    ret(32'hFFFF_FFFD);
    handler_i = 0;
    #0.4;
    expect_val(O_RD, 2, "R7 return process"); expect_val(O_SEL, 1, "R7"); flush();

    @(negedge clk_i);
    ret_valid_i = 1; ret_code_i = 32'h0000_1234;
    @(negedge clk_i);
    ret_valid_i = 0;
    #0.4;
    expect_val(O_ERR, 1, "R8 error pulse"); expect_val(O_RD, 2, "R8 no change"); flush();
    @(negedge clk_i);
    expect_val(O_ERR, 0, "R8 one cycle"); flush();

    ret(32'hFFFF_FFF9);
    expect_val(O_RD, 0, "R7 return main"); expect_val(O_SEL, 0, "R7"); flush();
    ret(32'hFFFF_FFFD);
    ret(32'hFFFF_FFF1);
    expect_val(O_RD, 2, "R7 handler code keeps select"); flush();
    ret(32'hFFFF_FFF9);
    drive(0, 0, 0, 0, 1, 0, 0);
    expect_val(O_CODE, 32'hFFFF_FFF9, "R9 thread main"); flush();

    drive(1, 2'b10, 1, 32'hFFFF_FFF9, 0, 0, 0);
    expect_val(O_RD, 0, "R11 return wins"); flush();

    csr_wr(2'b11);
    expect_val(O_PRIV, 0, "R5 unprivileged"); expect_val(O_SEL, 1, "R3");
    expect_val(O_RD, 0, "R6 read zero"); flush();
    csr_wr(2'b00);
    expect_val(O_PRIV, 0, "R6 no regain"); expect_val(O_SEL, 1, "R6 write ignored"); flush();

    @(negedge clk_i);
    handler_i = 1;
    #0.4;
    expect_val(O_RD, 1, "R6 handler sees bit0"); expect_val(O_PRIV, 1, "R5"); flush();
    csr_wr(2'b00);
    handler_i = 0;
    #0.4;
    expect_val(O_RD, 2, "R6 handler clears bit0"); expect_val(O_PRIV, 1, "R6"); flush();

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule